// File: doc/BRIEF.md
# Translation Window Register Bank

This block is the configuration store of a bus bridge's address translation unit. It holds four outbound windows (CPU address space to bus address space), three inbound windows (bus address space to CPU memory) and one free-running-timeout value that the bank only stores. Software reaches it through a simple single-cycle register bus. One address is shared by reads and writes, and there is a write strobe and a read strobe. Read data comes back one cycle after the read strobe.

Every stored field of every window is also driven out on flat parallel buses, so the translation datapath can use them directly. Each accepted write to a window register raises a one-cycle reload pulse. The pulse carries the direction and the index of that window, so downstream logic reloads only the window that changed. The register bus has no back-pressure: each strobe is taken in the cycle it is presented, and the reload pulse is a plain strobe with no ready.

Addresses are byte offsets within the 0x400-byte register block. Window groups are 32 bytes apart. The group number is `bus_addr[9:5]` and the offset within a group is `bus_addr[4:0]`.

Top module: `xwin_bank`

## Requirements
- R1: After reset, and again after any later reset, every stored word is zero, `rd_valid` and `upd_valid` are low, and every parallel field output reads zero.
- R2: Outbound windows sit at offsets 0x020, 0x040, 0x060 and 0x080, with index `bus_addr[7:5]` = 1..4. Within a group the fields are: translation at +0x00, translation extension at +0x04, base at +0x08 and attributes at +0x10. Window index k drives bits [(k-1)*32 +: 32] of the `ob_*` outputs.
- R3: Inbound windows sit at offsets 0x1A0, 0x1C0 and 0x1E0, with index `bus_addr[6:5]` minus one = 0..2. Within a group the fields are: translation at +0x00, base at +0x08, base extension at +0x0C and attributes at +0x10. Window index k drives bits [k*32 +: 32] of the `ib_*` outputs.
- R4: The timer word at offset 0x220 is plain read/write storage that appears on `timer_val`. Writing it raises no reload pulse.
- R5: A write to any decoded window field raises `upd_valid` for exactly the next cycle. In that cycle `upd_inbound` is 0 for an outbound window and 1 for an inbound one, and `upd_idx` carries the window index as defined in R2 and R3.
- R6: A write to an undecoded offset changes no stored word and raises no pulse. This includes unused offsets inside a window group, such as outbound +0x0C and inbound +0x04.
- R7: A read of an undecoded offset returns zero.
- R8: `rd_valid` is high in the cycle after `rd_en`, with `rd_data` holding the addressed word, and it is low in every other cycle.
- R9: The field offset is taken from all five low address bits, so +0x10 and +0x00 of a group are distinct words.
- R10: When a read and a write hit the same word in one cycle, the read returns the value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| bus_addr | input | 10 | Byte offset of the access |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data, valid with rd_valid |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |
| upd_valid | output | 1 | One-cycle window reload pulse |
| upd_inbound | output | 1 | Reload direction: 0 outbound, 1 inbound |
| upd_idx | output | 3 | Index of the window to reload |
| timer_val | output | 32 | Stored timer word |
| ob_xlat | output | 128 | Outbound translation words, one per window |
| ob_xlat_ext | output | 128 | Outbound translation extension words |
| ob_base | output | 128 | Outbound base words |
| ob_attr | output | 128 | Outbound attribute words |
| ib_xlat | output | 96 | Inbound translation words |
| ib_base | output | 96 | Inbound base words |
| ib_base_ext | output | 96 | Inbound base extension words |
| ib_attr | output | 96 | Inbound attribute words |

## Verification
The assertions watch, on every cycle, the fixed relations in time. `rd_valid` follows `rd_en` by exactly one cycle. A reload pulse only follows a write. The pulse index stays inside the legal range for its direction. The timer word holds while no write is made. Whether the address map is right can only be shown by the bench's scenarios: that each offset lands in the right field and window, that unused offsets inside a group neither store nor pulse, that +0x10 does not alias +0x00, and that a read and a write in the same cycle return the old value.

// File: rtl/xwin_pkg.sv
package xwin_pkg;

  // Location of the storage word inside a window.
  typedef enum logic [1:0] {
    SLOT_XLAT = 2'd0,
    SLOT_EXT  = 2'd1,
    SLOT_BASE = 2'd2,
    SLOT_ATTR = 2'd3
  } slot_e;

  localparam int SLOTS = 4;

  // Group numbers (address >> 5) of the window banks.
  localparam int OB_GRP_FIRST = 1;
  localparam int IB_GRP_LAST  = 15;

  // Byte offset of the timer word in the block.
  localparam int TMR_OFFSET = 'h220;

  // Field offsets inside a 32-byte group.
  localparam logic [4:0] OFF_XLAT   = 5'h00;
  localparam logic [4:0] OFF_OB_EXT = 5'h04;
  localparam logic [4:0] OFF_BASE   = 5'h08;
  localparam logic [4:0] OFF_IB_EXT = 5'h0C;
  localparam logic [4:0] OFF_ATTR   = 5'h10;

endpackage

// File: rtl/xwin_decode.sv
module xwin_decode
  import xwin_pkg::*;
#(
  parameter int AW     = 10,
  parameter int NUM_OB = 4,
  parameter int NUM_IB = 3,
  parameter int WIN_W  = 2
) (
  input  logic [AW-1:0]    addr,
  output logic             ob_hit,
  output logic             ib_hit,
  output logic             tmr_hit,
  output slot_e            slot,
  output logic [WIN_W-1:0] win,
  output logic [2:0]       tag
);
  localparam int GW = AW - 5;
  localparam logic [GW-1:0] OB_LO = GW'(OB_GRP_FIRST);
  localparam logic [GW-1:0] OB_HI = GW'(OB_GRP_FIRST + NUM_OB - 1);
  localparam logic [GW-1:0] IB_HI = GW'(IB_GRP_LAST);
  localparam logic [GW-1:0] IB_LO = GW'(IB_GRP_LAST - NUM_IB + 1);

  logic [GW-1:0] grp;
  logic [4:0]    off;
  logic          in_ob, in_ib;

  assign grp   = addr[AW-1:5];
  assign off   = addr[4:0];
  assign in_ob = (grp >= OB_LO) && (grp <= OB_HI);
  assign in_ib = (grp >= IB_LO) && (grp <= IB_HI);

  assign tmr_hit = (addr == AW'(TMR_OFFSET));

  always_comb begin
    ob_hit = 1'b0;
    ib_hit = 1'b0;
    slot   = SLOT_XLAT;
    win    = '0;
    tag    = '0;
    if (in_ob) begin
      win = WIN_W'(grp - OB_LO);
      tag = 3'(grp);
      ob_hit = 1'b1;
      case (off)
        OFF_XLAT:   slot = SLOT_XLAT;
        OFF_OB_EXT: slot = SLOT_EXT;
        OFF_BASE:   slot = SLOT_BASE;
        OFF_ATTR:   slot = SLOT_ATTR;
        default:    ob_hit = 1'b0;
      endcase
    end else if (in_ib) begin
      win = WIN_W'(grp - IB_LO);
      tag = 3'(grp - IB_LO);
      ib_hit = 1'b1;
      case (off)
        OFF_XLAT:   slot = SLOT_XLAT;
        OFF_IB_EXT: slot = SLOT_EXT;
        OFF_BASE:   slot = SLOT_BASE;
        OFF_ATTR:   slot = SLOT_ATTR;
        default:    ib_hit = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/xwin_window.sv
module xwin_window
  import xwin_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  slot_e                    slot,
  input  logic [DW-1:0]            wdata,
  output logic [SLOTS-1:0][DW-1:0] words
);
  for (genvar k = 0; k < SLOTS; k++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        words[k] <= '0;
      end else if (we && (slot == slot_e'(k))) begin
        words[k] <= wdata;
      end
    end
  end

endmodule

// File: rtl/xwin_notify.sv
module xwin_notify (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fire,
  input  logic       inbound,
  input  logic [2:0] tag,
  output logic       upd_valid,
  output logic       upd_inbound,
  output logic [2:0] upd_idx
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      upd_valid   <= 1'b0;
      upd_inbound <= 1'b0;
      upd_idx     <= '0;
    end else begin
      upd_valid   <= fire;
      upd_inbound <= fire ? inbound : 1'b0;
      upd_idx     <= fire ? tag : 3'd0;
    end
  end

endmodule

// File: rtl/xwin_bank.sv
module xwin_bank
  import xwin_pkg::*;
#(
  parameter int AW     = 10,
  parameter int DW     = 32,
  parameter int NUM_OB = 4,
  parameter int NUM_IB = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [AW-1:0]      bus_addr,
  input  logic [DW-1:0]      wr_data,
  output logic [DW-1:0]      rd_data,
  output logic               rd_valid,
  output logic               upd_valid,
  output logic               upd_inbound,
  output logic [2:0]         upd_idx,
  output logic [DW-1:0]      timer_val,
  output logic [NUM_OB*DW-1:0] ob_xlat,
  output logic [NUM_OB*DW-1:0] ob_xlat_ext,
  output logic [NUM_OB*DW-1:0] ob_base,
  output logic [NUM_OB*DW-1:0] ob_attr,
  output logic [NUM_IB*DW-1:0] ib_xlat,
  output logic [NUM_IB*DW-1:0] ib_base,
  output logic [NUM_IB*DW-1:0] ib_base_ext,
  output logic [NUM_IB*DW-1:0] ib_attr
);
  localparam int NMAX  = (NUM_OB > NUM_IB) ? NUM_OB : NUM_IB;
  localparam int WIN_W = (NMAX > 1) ? $clog2(NMAX) : 1;

  logic             ob_hit, ib_hit, tmr_hit;
  slot_e            slot;
  logic [WIN_W-1:0] win;
  logic [2:0]       tag;

  xwin_decode #(
    .AW(AW), .NUM_OB(NUM_OB), .NUM_IB(NUM_IB), .WIN_W(WIN_W)
  ) u_dec (
    .addr(bus_addr), .ob_hit(ob_hit), .ib_hit(ib_hit), .tmr_hit(tmr_hit),
    .slot(slot), .win(win), .tag(tag)
  );

  logic [SLOTS-1:0][DW-1:0] ob_words [NUM_OB];
  logic [SLOTS-1:0][DW-1:0] ib_words [NUM_IB];

  for (genvar g = 0; g < NUM_OB; g++) begin : g_ob
    logic we;
    assign we = wr_en && ob_hit && (win == WIN_W'(g));
    xwin_window #(.DW(DW)) u_win (
      .clk(clk), .rst_n(rst_n), .we(we), .slot(slot),
      .wdata(wr_data), .words(ob_words[g])
    );
    assign ob_xlat[g*DW +: DW]     = ob_words[g][SLOT_XLAT];
    assign ob_xlat_ext[g*DW +: DW] = ob_words[g][SLOT_EXT];
    assign ob_base[g*DW +: DW]     = ob_words[g][SLOT_BASE];
    assign ob_attr[g*DW +: DW]     = ob_words[g][SLOT_ATTR];
  end

  for (genvar g = 0; g < NUM_IB; g++) begin : g_ib
    logic we;
    assign we = wr_en && ib_hit && (win == WIN_W'(g));
    xwin_window #(.DW(DW)) u_win (
      .clk(clk), .rst_n(rst_n), .we(we), .slot(slot),
      .wdata(wr_data), .words(ib_words[g])
    );
    assign ib_xlat[g*DW +: DW]     = ib_words[g][SLOT_XLAT];
    assign ib_base_ext[g*DW +: DW] = ib_words[g][SLOT_EXT];
    assign ib_base[g*DW +: DW]     = ib_words[g][SLOT_BASE];
    assign ib_attr[g*DW +: DW]     = ib_words[g][SLOT_ATTR];
  end

  // Timer word: storage only.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      timer_val <= '0;
    end else if (wr_en && tmr_hit) begin
      timer_val <= wr_data;
    end
  end

  // Read path: the mux sees the words before this edge's write.
  logic [DW-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (ob_hit) begin
      rd_mux = ob_words[win][slot];
    end else if (ib_hit) begin
      rd_mux = ib_words[win][slot];
    end else if (tmr_hit) begin
      rd_mux = timer_val;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      rd_data  <= rd_en ? rd_mux : '0;
    end
  end

  xwin_notify u_ntf (
    .clk(clk), .rst_n(rst_n),
    .fire(wr_en && (ob_hit || ib_hit)),
    .inbound(ib_hit), .tag(tag),
    .upd_valid(upd_valid), .upd_inbound(upd_inbound), .upd_idx(upd_idx)
  );

endmodule

// File: rtl/xwin_bank_chk.sv
module xwin_bank_chk #(
  parameter int DW     = 32,
  parameter int NUM_OB = 4,
  parameter int NUM_IB = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic          rd_en,
  input logic          rd_valid,
  input logic          upd_valid,
  input logic          upd_inbound,
  input logic [2:0]    upd_idx,
  input logic [DW-1:0] timer_val
);
  // R8
  rd_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);

  // R8
  rd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);

  // R5
  upd_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |-> $past(wr_en));

  // R6
  no_spurious_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> !upd_valid);

  // R5
  ob_idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !upd_inbound) |-> (upd_idx >= 3'd1 && upd_idx <= 3'(NUM_OB)));

  // R5
  ib_idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_inbound) |-> (upd_idx < 3'(NUM_IB)));

  // R4
  tmr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(timer_val));

endmodule

bind xwin_bank xwin_bank_chk #(
  .DW(DW), .NUM_OB(NUM_OB), .NUM_IB(NUM_IB)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
  .rd_valid(rd_valid), .upd_valid(upd_valid), .upd_inbound(upd_inbound),
  .upd_idx(upd_idx), .timer_val(timer_val)
);

// File: tb/xwin_bank_bench.sv
module xwin_bank_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [9:0]  bus_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data, timer_val;
  logic        rd_valid, upd_valid, upd_inbound;
  logic [2:0]  upd_idx;
  logic [127:0] ob_xlat, ob_xlat_ext, ob_base, ob_attr;
  logic [95:0]  ib_xlat, ib_base, ib_base_ext, ib_attr;

  int n_cmp = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  xwin_bank u_xwin_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .bus_addr(bus_addr), .wr_data(wr_data), .rd_data(rd_data),
    .rd_valid(rd_valid), .upd_valid(upd_valid), .upd_inbound(upd_inbound),
    .upd_idx(upd_idx), .timer_val(timer_val),
    .ob_xlat(ob_xlat), .ob_xlat_ext(ob_xlat_ext), .ob_base(ob_base),
    .ob_attr(ob_attr), .ib_xlat(ib_xlat), .ib_base(ib_base),
    .ib_base_ext(ib_base_ext), .ib_attr(ib_attr)
  );

  typedef struct packed {
    logic        wr;
    logic [9:0]  addr;
    logic [31:0] data;
    logic [31:0] exp_rd;
    logic        exp_upd;
    logic        exp_in;
    logic [2:0]  exp_idx;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 10'h020, 32'hAAAA0001, 32'h0,        1'b1, 1'b0, 3'd1, 4'd2},  // R2
    '{1'b1, 10'h030, 32'h11110010, 32'h0,        1'b1, 1'b0, 3'd1, 4'd2},  // R2
    '{1'b1, 10'h050, 32'h80000005, 32'h0,        1'b1, 1'b0, 3'd2, 4'd9},  // R9
    '{1'b1, 10'h08C, 32'h00000055, 32'h0,        1'b0, 1'b0, 3'd0, 4'd6},  // R6
    '{1'b1, 10'h0A0, 32'h00000066, 32'h0,        1'b0, 1'b0, 3'd0, 4'd6},  // R6
    '{1'b1, 10'h1E8, 32'hCAFE0008, 32'h0,        1'b1, 1'b1, 3'd2, 4'd3},  // R3
    '{1'b1, 10'h1AC, 32'h0BEEF00C, 32'h0,        1'b1, 1'b1, 3'd0, 4'd3},  // R3
    '{1'b1, 10'h1A4, 32'h0000DEAD, 32'h0,        1'b0, 1'b0, 3'd0, 4'd6},  // R6
    '{1'b1, 10'h220, 32'h12345678, 32'h0,        1'b0, 1'b0, 3'd0, 4'd4},  // R4
    '{1'b1, 10'h064, 32'h00007777, 32'h0,        1'b1, 1'b0, 3'd3, 4'd2},  // R2
    '{1'b1, 10'h000, 32'h00000099, 32'h0,        1'b0, 1'b0, 3'd0, 4'd6},  // R6
    '{1'b0, 10'h020, 32'h0, 32'hAAAA0001,        1'b0, 1'b0, 3'd0, 4'd2},  // R2
    '{1'b0, 10'h030, 32'h0, 32'h11110010,        1'b0, 1'b0, 3'd0, 4'd2},  // R2
    '{1'b0, 10'h040, 32'h0, 32'h00000000,        1'b0, 1'b0, 3'd0, 4'd9},  // R9
    '{1'b0, 10'h050, 32'h0, 32'h80000005,        1'b0, 1'b0, 3'd0, 4'd9},  // R9
    '{1'b0, 10'h08C, 32'h0, 32'h00000000,        1'b0, 1'b0, 3'd0, 4'd7},  // R7
    '{1'b0, 10'h0A0, 32'h0, 32'h00000000,        1'b0, 1'b0, 3'd0, 4'd7},  // R7
    '{1'b0, 10'h1E8, 32'h0, 32'hCAFE0008,        1'b0, 1'b0, 3'd0, 4'd3},  // R3
    '{1'b0, 10'h1AC, 32'h0, 32'h0BEEF00C,        1'b0, 1'b0, 3'd0, 4'd3},  // R3
    '{1'b0, 10'h1A4, 32'h0, 32'h00000000,        1'b0, 1'b0, 3'd0, 4'd7},  // R7
    '{1'b0, 10'h220, 32'h0, 32'h12345678,        1'b0, 1'b0, 3'd0, 4'd4},  // R4
    '{1'b0, 10'h064, 32'h0, 32'h00007777,        1'b0, 1'b0, 3'd0, 4'd2},  // R2
    '{1'b0, 10'h3FC, 32'h0, 32'h00000000,        1'b0, 1'b0, 3'd0, 4'd7}   // R7
  };

  task automatic check(input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    wr_en = 1'b0;
    rd_en = 1'b0;
  endtask

  initial begin
    #4000000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1", "rd_valid", rd_valid, 0);
    check("R1", "upd_valid", upd_valid, 0);
    check("R1", "timer", timer_val, 0);
    check("R1", "ob_attr", ob_attr, 0);
    check("R1", "ib_xlat", ib_xlat, 0);
    rd_en = 1'b1; bus_addr = 10'h030;
    @(negedge clk);
    check("R1", "rd after reset", rd_data, 0);
    idle();
    @(negedge clk);
    // R8: no read gives rd_valid low
    check("R8", "rd_valid idle", rd_valid, 0);

    for (int i = 0; i < NV; i++) begin
      wr_en    = TBL[i].wr;
      rd_en    = !TBL[i].wr;
      bus_addr = TBL[i].addr;
      wr_data  = TBL[i].data;
      @(negedge clk);
      if (TBL[i].wr) begin
        check($sformatf("R%0d", TBL[i].req), "upd_valid", upd_valid, TBL[i].exp_upd);
        if (TBL[i].exp_upd) begin
          check("R5", "upd_inbound", upd_inbound, TBL[i].exp_in);
          check("R5", "upd_idx", upd_idx, TBL[i].exp_idx);
        end
      end else begin
        check("R8", "rd_valid", rd_valid, 1);
        check($sformatf("R%0d", TBL[i].req), "rd_data", rd_data, TBL[i].exp_rd);
      end
    end
    idle();
    @(negedge clk);
    check("R5", "pulse one cycle", upd_valid, 0);

    // Parallel field outputs
    check("R2", "ob_xlat w1", ob_xlat[31:0], 32'hAAAA0001);
    check("R2", "ob_attr w1", ob_attr[31:0], 32'h11110010);
    check("R9", "ob_attr w2", ob_attr[63:32], 32'h80000005);
    check("R9", "ob_xlat w2", ob_xlat[63:32], 32'h0);
    check("R2", "ob_xlat_ext w3", ob_xlat_ext[95:64], 32'h00007777);
    check("R3", "ib_base w2", ib_base[95:64], 32'hCAFE0008);
    check("R3", "ib_base_ext w0", ib_base_ext[31:0], 32'h0BEEF00C);
    check("R4", "timer_val", timer_val, 32'h12345678);
    check("R6", "ob w4 untouched", {ob_xlat[127:96], ob_xlat_ext[127:96],
                                    ob_base[127:96], ob_attr[127:96]}, 0);
    check("R6", "ib w0 +4 untouched", {ib_xlat[31:0], ib_base[31:0], ib_attr[31:0]}, 0);

    // R10: read and write of one word in one cycle
    wr_en = 1'b1; rd_en = 1'b1; bus_addr = 10'h020; wr_data = 32'h5A5A5A5A;
    @(negedge clk);
    check("R10", "old value", rd_data, 32'hAAAA0001);
    check("R5", "upd with read", upd_valid, 1);
    wr_en = 1'b0;
    @(negedge clk);
    check("R10", "new value", rd_data, 32'h5A5A5A5A);
    idle();

    // R5: back-to-back writes to two windows give two pulses
    wr_en = 1'b1; bus_addr = 10'h1C0; wr_data = 32'h1;
    @(negedge clk);
    check("R5", "b2b first", {upd_valid, upd_inbound, upd_idx}, {1'b1, 1'b1, 3'd1});
    bus_addr = 10'h080; wr_data = 32'h2;
    @(negedge clk);
    check("R5", "b2b second", {upd_valid, upd_inbound, upd_idx}, {1'b1, 1'b0, 3'd4});
    idle();
    @(negedge clk);
    check("R3", "ib_xlat w1", ib_xlat[63:32], 32'h1);
    check("R2", "ob_xlat w4", ob_xlat[127:96], 32'h2);

    // R1: reset after traffic
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "timer after reset", timer_val, 0);
    check("R1", "ob_xlat after reset", ob_xlat, 0);
    check("R1", "ib_base after reset", ib_base, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule